// File: doc/BRIEF.md
# Variable-Width Peripheral Bus Adapter

This block joins a 32-bit processor bus to one peripheral that decides how wide each of its transfers is. For every chunk it wants to move, the peripheral gives a 2-bit size code. Three codes pick a chunk of one, two or four bytes. The fourth code means the peripheral is waiting, and nothing moves while it is held. In the outbound direction, the adapter takes whole words from the processor and hands them to the peripheral chunk by chunk. In the inbound direction, it gathers the peripheral's chunks and offers whole words back to the processor. Each of the four sides uses a valid/ready handshake.

Bytes always move in little-endian order, starting at byte 0 of a word. A chunk may need more bytes than are left in the current word. In that case the adapter holds the peripheral off until the next word arrives. It then builds the chunk from the leftover bytes in the low lanes and the new word's first bytes above them. A build-time parameter switches the adapter to static width. In that mode every chunk is a single byte, whatever the size lines show, and the wait code is also treated as one byte.

Top module: `vw_bus_adapter`

## Requirements
- R1: After a synchronous reset the adapter holds no data in either direction. `p_get_ready` and `s_rvalid` are low, `s_wready` is high, and `p_put_ready` is high for any non-wait size code.
- R2: Size codes select chunk widths: 2'b01 selects 1 byte, 2'b10 selects 2 bytes and 2'b11 selects 4 bytes. An outbound chunk sits in the low bytes of `p_get_data`, and the bytes above it read as zero.
- R3: When static mode is off, size code 2'b00 means wait. While it is present, `p_get_ready` and `p_put_ready` are low and no byte moves in either direction.
- R4: Outbound chunks are taken from each word in ascending byte order, from byte 0 to byte 3. Inbound chunks fill a word in the same order.
- R5: A new processor word is accepted only while fewer than 4 unconsumed bytes are held. `s_wready` is low whenever a full word or more is still waiting.
- R6: If the requested chunk is wider than the bytes held, `p_get_ready` stays low until the next word has been accepted. The chunk then holds the leftover bytes in its low lanes, followed by the new word's first bytes.
- R7: A chunk moves only in a cycle where the peripheral's valid and the adapter's ready are both high. A cycle with ready high but valid low consumes nothing.
- R8: Inbound chunks are packed into a word, and `s_rvalid` rises once 4 bytes are collected. Bytes of `p_put_data` above the chunk width are ignored. `s_rdata` holds steady while `s_rready` is low.
- R9: The inbound side stores at most 8 bytes. `p_put_ready` is low whenever the requested chunk would not fit in the free space.
- R10: With `STATIC_BYTE` set, every transfer in both directions is exactly 1 byte, for every size code including 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_wvalid | input | 1 | Processor offers a word for the peripheral |
| s_wready | output | 1 | Adapter can take a word |
| s_wdata | input | DATA_W | Word from the processor |
| s_rvalid | output | 1 | A packed word is ready for the processor |
| s_rready | input | 1 | Processor takes the packed word |
| s_rdata | output | DATA_W | Packed word to the processor |
| p_get_size | input | 2 | Outbound chunk size code |
| p_get_valid | input | 1 | Peripheral asks for an outbound chunk |
| p_get_ready | output | 1 | Enough bytes are held for the requested chunk |
| p_get_data | output | DATA_W | Outbound chunk in the low bytes, upper bytes zero |
| p_put_size | input | 2 | Inbound chunk size code |
| p_put_valid | input | 1 | Peripheral offers an inbound chunk |
| p_put_ready | output | 1 | The chunk fits in the inbound store |
| p_put_data | input | DATA_W | Inbound chunk in the low bytes |

## Verification
Some properties are checked on every cycle. The wait code never raises either ready. Neither store goes past its byte limit. The outbound byte pointer always agrees with the count of held bytes. A waiting packed word keeps its value. Static mode never yields an outbound chunk wider than one byte. Other behaviour needs directed scenarios at the ports. These cover the actual byte order in chunks, how leftover bytes combine with the next word, the masking of unused inbound lanes, and the fact that a stalled or idle cycle leaves the next chunk unchanged.

// File: rtl/vwa_pkg.sv
package vwa_pkg;

  typedef enum logic [1:0] {
    SZ_HOLD = 2'b00,
    SZ_ONE  = 2'b01,
    SZ_TWO  = 2'b10,
    SZ_FULL = 2'b11
  } size_code_e;

  // Number of bytes a size code asks for, for a word of wb bytes.
  function automatic int unsigned code_to_bytes(input logic [1:0] code, input int unsigned wb);
    case (size_code_e'(code))
      SZ_ONE:  return 1;
      SZ_TWO:  return 2;
      SZ_FULL: return wb;
      default: return 0;
    endcase
  endfunction

  // Bit offset of a byte position.
  function automatic int unsigned lane_bits(input int unsigned nbytes);
    return nbytes * 8;
  endfunction

endpackage

// File: rtl/vwa_size_decode.sv
module vwa_size_decode #(
  parameter int WB          = 4,
  parameter bit STATIC_BYTE = 1'b0,
  parameter int CW          = $clog2(2*WB+1)
) (
  input  logic [1:0]    code,
  output logic [CW-1:0] nbytes
);
  import vwa_pkg::*;

  generate
    if (STATIC_BYTE) begin : g_fixed
      assign nbytes = CW'(1);
    end else begin : g_dynamic
      always_comb nbytes = CW'(code_to_bytes(code, WB));
    end
  endgenerate

endmodule

// File: rtl/vwa_tx_unpack.sv
module vwa_tx_unpack #(
  parameter int DW = 32,
  parameter int WB = DW/8,
  parameter int CW = $clog2(2*WB+1),
  parameter int PW = (WB > 1) ? $clog2(WB) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          word_valid,
  output logic          word_ready,
  input  logic [DW-1:0] word_data,
  input  logic [CW-1:0] chunk_n,
  input  logic          chunk_valid,
  output logic          chunk_ready,
  output logic [DW-1:0] chunk_data
);
  import vwa_pkg::*;

  function automatic logic [DW-1:0] low_mask(input logic [CW-1:0] n);
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < WB; i++)
      if (CW'(i) < n) m[8*i +: 8] = 8'hFF;
    return m;
  endfunction

  logic [2*DW-1:0] hold_q, hold_d;
  logic [CW-1:0]   cnt_q, cnt_d, take;
  logic [PW-1:0]   ptr_q, ptr_d;
  logic            word_fire, chunk_fire, chunk_stall;

  assign word_ready  = (cnt_q < CW'(WB));
  assign chunk_ready = (chunk_n != '0) && (cnt_q >= chunk_n);
  assign word_fire   = word_valid && word_ready;
  assign chunk_fire  = chunk_valid && chunk_ready;
  assign chunk_stall = chunk_valid && !chunk_ready;
  assign take        = chunk_fire ? chunk_n : '0;
  assign chunk_data  = hold_q[DW-1:0] & low_mask(chunk_n);

  always_comb begin
    hold_d = hold_q >> lane_bits(int'(take));
    cnt_d  = cnt_q - take;
    if (word_fire) begin
      hold_d = hold_d | ({{DW{1'b0}}, word_data} << lane_bits(int'(cnt_d)));
      cnt_d  = cnt_d + CW'(WB);
    end
    ptr_d = ptr_q + PW'(take);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      cnt_q  <= '0;
      ptr_q  <= '0;
    end else begin
      hold_q <= hold_d;
      cnt_q  <= cnt_d;
      ptr_q  <= ptr_d;
    end
  end

  AST_TX_FILL_LIMIT: assert property (@(posedge clk) disable iff (rst) cnt_q <= CW'(2*WB-1)); // R5
  AST_TX_STALL_KEEPS: assert property (@(posedge clk) disable iff (rst) (chunk_stall && !word_fire) |=> $stable(cnt_q)); // R7
  AST_TX_PTR_ALIGN: assert property (@(posedge clk) disable iff (rst) ptr_q == PW'(CW'(0) - cnt_q)); // R4

endmodule

// File: rtl/vwa_rx_pack.sv
module vwa_rx_pack #(
  parameter int DW = 32,
  parameter int WB = DW/8,
  parameter int CW = $clog2(2*WB+1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] chunk_n,
  input  logic          chunk_valid,
  output logic          chunk_ready,
  input  logic [DW-1:0] chunk_data,
  output logic          word_valid,
  input  logic          word_ready,
  output logic [DW-1:0] word_data
);
  import vwa_pkg::*;

  function automatic logic [DW-1:0] low_mask(input logic [CW-1:0] n);
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < WB; i++)
      if (CW'(i) < n) m[8*i +: 8] = 8'hFF;
    return m;
  endfunction

  logic [2*DW-1:0] hold_q, hold_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            pop, chunk_fire;
  logic [CW:0]     fill_if_taken;

  assign fill_if_taken = {1'b0, cnt_q} + {1'b0, chunk_n};
  assign word_valid    = (cnt_q >= CW'(WB));
  assign word_data     = hold_q[DW-1:0];
  assign chunk_ready   = (chunk_n != '0) && (fill_if_taken <= (CW+1)'(2*WB));
  assign pop           = word_valid && word_ready;
  assign chunk_fire    = chunk_valid && chunk_ready;

  always_comb begin
    hold_d = pop ? (hold_q >> DW) : hold_q;
    cnt_d  = pop ? (cnt_q - CW'(WB)) : cnt_q;
    if (chunk_fire) begin
      hold_d = hold_d | ({{DW{1'b0}}, chunk_data & low_mask(chunk_n)} << lane_bits(int'(cnt_d)));
      cnt_d  = cnt_d + chunk_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      cnt_q  <= '0;
    end else begin
      hold_q <= hold_d;
      cnt_q  <= cnt_d;
    end
  end

  AST_RX_HOLD_WORD: assert property (@(posedge clk) disable iff (rst) (word_valid && !word_ready) |=> (word_valid && $stable(word_data))); // R8
  AST_RX_CAPACITY: assert property (@(posedge clk) disable iff (rst) cnt_q <= CW'(2*WB)); // R9

endmodule

// File: rtl/vw_bus_adapter.sv
module vw_bus_adapter #(
  parameter int DATA_W      = 32,
  parameter bit STATIC_BYTE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_wvalid,
  output logic              s_wready,
  input  logic [DATA_W-1:0] s_wdata,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [DATA_W-1:0] s_rdata,
  input  logic [1:0]        p_get_size,
  input  logic              p_get_valid,
  output logic              p_get_ready,
  output logic [DATA_W-1:0] p_get_data,
  input  logic [1:0]        p_put_size,
  input  logic              p_put_valid,
  output logic              p_put_ready,
  input  logic [DATA_W-1:0] p_put_data
);
  localparam int WB = DATA_W / 8;
  localparam int CW = $clog2(2*WB+1);

  logic [CW-1:0] get_n, put_n;
  logic          get_is_wait, put_is_wait;

  assign get_is_wait = (p_get_size == 2'b00) && !STATIC_BYTE;
  assign put_is_wait = (p_put_size == 2'b00) && !STATIC_BYTE;

  vwa_size_decode #(.WB(WB), .STATIC_BYTE(STATIC_BYTE), .CW(CW)) u_get_dec (
    .code   (p_get_size),
    .nbytes (get_n)
  );

  vwa_size_decode #(.WB(WB), .STATIC_BYTE(STATIC_BYTE), .CW(CW)) u_put_dec (
    .code   (p_put_size),
    .nbytes (put_n)
  );

  vwa_tx_unpack #(.DW(DATA_W), .WB(WB), .CW(CW)) u_tx (
    .clk         (clk),
    .rst         (rst),
    .word_valid  (s_wvalid),
    .word_ready  (s_wready),
    .word_data   (s_wdata),
    .chunk_n     (get_n),
    .chunk_valid (p_get_valid),
    .chunk_ready (p_get_ready),
    .chunk_data  (p_get_data)
  );

  vwa_rx_pack #(.DW(DATA_W), .WB(WB), .CW(CW)) u_rx (
    .clk         (clk),
    .rst         (rst),
    .chunk_n     (put_n),
    .chunk_valid (p_put_valid),
    .chunk_ready (p_put_ready),
    .chunk_data  (p_put_data),
    .word_valid  (s_rvalid),
    .word_ready  (s_rready),
    .word_data   (s_rdata)
  );

  AST_GET_WAIT_BLOCKS: assert property (@(posedge clk) disable iff (rst) get_is_wait |-> !p_get_ready); // R3
  AST_PUT_WAIT_BLOCKS: assert property (@(posedge clk) disable iff (rst) put_is_wait |-> !p_put_ready); // R3
  AST_STATIC_ONE_BYTE: assert property (@(posedge clk) disable iff (rst) (STATIC_BYTE && p_get_ready) |-> (p_get_data[DATA_W-1:8] == '0)); // R10

endmodule

// File: tb/sim_vw_bus_adapter.sv
module sim_vw_bus_adapter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  int vectors = 0;
  int misses  = 0;
  bit done    = 1'b0;

  // dynamic instance signals
  logic        a_wv = 0, a_wr, a_rv, a_rr = 0, a_gv = 0, a_gr, a_pv = 0, a_pr;
  logic [31:0] a_wd = 0, a_rd, a_gd, a_pd = 0;
  logic [1:0]  a_gs = 0, a_ps = 0;
  // static instance signals
  logic        b_wv = 0, b_wr, b_rv, b_rr = 0, b_gv = 0, b_gr, b_pv = 0, b_pr;
  logic [31:0] b_wd = 0, b_rd, b_gd, b_pd = 0;
  logic [1:0]  b_gs = 0, b_ps = 0;

  vw_bus_adapter #(.DATA_W(32), .STATIC_BYTE(1'b0)) u0 (
    .clk(clk), .rst(rst),
    .s_wvalid(a_wv), .s_wready(a_wr), .s_wdata(a_wd),
    .s_rvalid(a_rv), .s_rready(a_rr), .s_rdata(a_rd),
    .p_get_size(a_gs), .p_get_valid(a_gv), .p_get_ready(a_gr), .p_get_data(a_gd),
    .p_put_size(a_ps), .p_put_valid(a_pv), .p_put_ready(a_pr), .p_put_data(a_pd)
  );

  vw_bus_adapter #(.DATA_W(32), .STATIC_BYTE(1'b1)) u1 (
    .clk(clk), .rst(rst),
    .s_wvalid(b_wv), .s_wready(b_wr), .s_wdata(b_wd),
    .s_rvalid(b_rv), .s_rready(b_rr), .s_rdata(b_rd),
    .p_get_size(b_gs), .p_get_valid(b_gv), .p_get_ready(b_gr), .p_get_data(b_gd),
    .p_put_size(b_ps), .p_put_valid(b_pv), .p_put_ready(b_pr), .p_put_data(b_pd)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic t_reset();
    a_gv = 1; a_gs = 2'b11; a_ps = 2'b11; #1;
    chk("R1 get_ready after reset", 32'(a_gr), 32'd0);
    chk("R1 s_rvalid after reset", 32'(a_rv), 32'd0);
    chk("R1 s_wready after reset", 32'(a_wr), 32'd1);
    chk("R1 put_ready after reset", 32'(a_pr), 32'd1);
    a_gv = 0;
  endtask

  task automatic t_outbound();
    a_wv = 1; a_wd = 32'h44332211; cyc(); a_wv = 0; #1;
    chk("R5 s_wready low with a full word held", 32'(a_wr), 32'd0);
    a_gv = 1; a_gs = 2'b00; #1;
    chk("R3 get_ready low on wait code", 32'(a_gr), 32'd0);
    cyc();
    a_gs = 2'b01; #1;
    chk("R3 wait consumed nothing / R2 1-byte ready", 32'(a_gr), 32'd1);
    chk("R4 first byte is byte 0", a_gd, 32'h00000011);
    cyc();
    a_gs = 2'b10; #1;
    chk("R2 R4 2-byte chunk", a_gd, 32'h00003322);
    cyc();
    a_gs = 2'b11; #1;
    chk("R6 stall when 4 bytes asked and 1 held", 32'(a_gr), 32'd0);
    chk("R5 s_wready high with 1 byte left", 32'(a_wr), 32'd1);
    a_wv = 1; a_wd = 32'h88776655; cyc(); a_wv = 0; #1;
    chk("R6 ready after next word", 32'(a_gr), 32'd1);
    chk("R6 leftover combined with new word", a_gd, 32'h77665544);
    cyc();
    a_gv = 0; a_gs = 2'b01; cyc();
    a_gv = 1; #1;
    chk("R7 idle cycle consumed nothing", a_gd, 32'h00000088);
    cyc(); #1;
    chk("R6 empty store not ready", 32'(a_gr), 32'd0);
    a_wv = 1; a_wd = 32'hDDCCBBAA; cyc(); a_wv = 0; #1;
    chk("R2 upper bytes zero on 1-byte chunk", a_gd, 32'h000000AA);
    a_gs = 2'b11; #1;
    chk("R2 full word chunk", a_gd, 32'hDDCCBBAA);
    cyc(); a_gv = 0;
  endtask

  task automatic t_inbound();
    a_rr = 0; a_pv = 1; a_ps = 2'b01; a_pd = 32'hFFFFFF01; #1;
    chk("R8 put_ready for 1 byte", 32'(a_pr), 32'd1);
    cyc(); #1;
    chk("R8 no word after 1 byte", 32'(a_rv), 32'd0);
    a_ps = 2'b10; a_pd = 32'hFFFF0302; cyc(); #1;
    chk("R8 no word after 3 bytes", 32'(a_rv), 32'd0);
    a_ps = 2'b01; a_pd = 32'hAAAAAA04; cyc(); #1;
    chk("R8 word valid after 4 bytes", 32'(a_rv), 32'd1);
    chk("R8 R4 packed word, upper lanes ignored", a_rd, 32'h04030201);
    a_ps = 2'b11; a_pd = 32'h08070605; #1;
    chk("R9 4-byte chunk fits", 32'(a_pr), 32'd1);
    cyc();
    a_ps = 2'b01; #1;
    chk("R9 full store refuses a byte", 32'(a_pr), 32'd0);
    a_ps = 2'b00; #1;
    chk("R3 put_ready low on wait code", 32'(a_pr), 32'd0);
    a_pv = 0; cyc(); #1;
    chk("R8 word held while not taken", a_rd, 32'h04030201);
    a_rr = 1; cyc(); #1;
    chk("R8 second word follows", a_rd, 32'h08070605);
    chk("R8 second word valid", 32'(a_rv), 32'd1);
    cyc(); #1;
    chk("R8 drained", 32'(a_rv), 32'd0);
    a_rr = 0;
  endtask

  task automatic t_static();
    b_wv = 1; b_wd = 32'h0D0C0B0A; cyc(); b_wv = 0;
    b_gv = 1; b_gs = 2'b00; #1;
    chk("R10 wait code still gives a byte", 32'(b_gr), 32'd1);
    chk("R10 first byte", b_gd, 32'h0000000A);
    cyc();
    b_gs = 2'b11; #1;
    chk("R10 full code gives one byte", b_gd, 32'h0000000B);
    cyc(); b_gv = 0;
    b_rr = 0; b_pv = 1; b_ps = 2'b11; b_pd = 32'h11223344; #1;
    chk("R10 put ready", 32'(b_pr), 32'd1);
    cyc();
    b_ps = 2'b00; b_pd = 32'h00000055; cyc();
    b_ps = 2'b10; b_pd = 32'h00000066; cyc();
    b_ps = 2'b01; b_pd = 32'h00000077; cyc();
    b_pv = 0; #1;
    chk("R10 four single bytes packed", b_rd, 32'h77665544);
    chk("R10 word valid", 32'(b_rv), 32'd1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset();
    t_outbound();
    t_inbound();
    t_static();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule